// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Byte-Wide Register Access

This block is a 16-bit up-counter that a processor reaches through an 8-bit register bus. It counts either a one-cycle internal tick (the instruction-cycle strobe, one system clock wide) or rising edges seen on an external clock pin. Before reaching the counter, the selected events pass through a prescaler that divides by 1, 2, 4 or 8. The external pin is always captured into the system clock domain. A control bit picks one of two paths. The synchronized path edge-detects after the full synchronizer. The asynchronous-counter path taps the first capture stage, so each external edge lands one system clock sooner.

When the count wraps from all ones to zero, a sticky interrupt flag is set. Software writes that flag to clear it. A one-cycle trigger from a compare unit clears the whole count to zero. Software reads and writes the count in one of two ways. In direct byte mode, each byte is its own register. In buffered 16-bit mode, a shadow high byte makes two-byte reads and writes atomic: reading the low byte snapshots the high byte, and writing the low byte commits the shadow high byte together with it.

Top module: `ptmr16`

## Requirements
- R1: After reset the control register, the count and the interrupt flag are all zero.
- R2: In timer mode (control bit 1 = 0) with the enable (bit 0) set and a prescaler ratio of 1, the count rises by exactly one for each clock in which `tick_i` is high.
- R3: The prescaler field (control bits 5:4) gives division ratios 1, 2, 4 and 8 for codes 00, 01, 10 and 11. The count advances on the Nth selected event after the prescaler was last cleared.
- R4: With the enable bit at 0, no event changes the count.
- R5: In counter mode (control bit 1 = 1), the count advances on rising edges of `ext_clk_i`, through the prescaler, and `tick_i` is ignored.
- R6: With control bit 2 = 0 (synchronized path), a rising edge on `ext_clk_i` before clock edge k raises the count after edge k+2. With bit 2 = 1 (asynchronous-counter path), it raises the count after edge k+1.
- R7: A wrap of the count from 0xFFFF to 0x0000 sets the flag (register 3, bit 0). The flag stays set until software writes 0 to register 3, and an overflow in the same cycle wins over that write.
- R8: A high `evt_clr_i` clears the count to 0 at the next clock edge, even if a count event occurs in the same cycle.
- R9: In buffered mode (control bit 7 = 1), a read of the low byte (register 1) copies the live high byte into the shadow. Register 2 then returns the shadow, not the live high byte.
- R10: In buffered mode, a write to register 2 changes only the shadow. A later write to register 1 loads the shadow and the written byte into the count together.
- R11: In direct mode (control bit 7 = 0), registers 1 and 2 read and write the live low and high count bytes independently.
- R12: The control register (register 0) keeps bits 0, 1, 2, 4, 5 and 7 and reads 0 in bits 3 and 6.
- R13: Any write to the count clears the prescaler's partial progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal instruction-cycle tick, one clock wide |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| evt_clr_i | input | 1 | Compare-unit trigger that clears the count |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (for read side effects) |
| addr_i | input | 2 | Register select: 0 control, 1 count low, 2 count high, 3 flag |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_flag_o | output | 1 | Sticky overflow interrupt flag |

## Verification
The counting function is driven with plain tick bursts at each prescaler code. Burst lengths of 16, 3 and 4 separate a correct ratio from an off-by-one in the divider. External pulses are applied with `tick_i` held high, which shows that the source select really ignores the unselected input. Single external edges are sampled one and two clocks after capture, which separates the synchronized path from the asynchronous-counter path. Counts that straddle a byte boundary (0x12FF, 0xFFFE) distinguish the shadow byte from the live high byte and a genuine wrap from a stuck counter.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 2 * BYTE_W;
  localparam int PSC_SEL_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNTL = 2'd1,
    REG_CNTH = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  // control register image, bit 7 down to bit 0
  typedef struct packed {
    logic                 mode16;
    logic                 rsv6;
    logic [PSC_SEL_W-1:0] psc_sel;
    logic                 rsv3;
    logic                 nosync;
    logic                 ext_sel;
    logic                 en;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hB7;
endpackage

// File: rtl/ptmr_edge.sv
module ptmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic bypass_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], ext_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  // asynchronous-counter path taps the first capture stage
  always_comb begin
    if (bypass_i) rise_o = sh_q[0] & ~sh_q[1];
    else          rise_o = sh_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             adv_o
);
  localparam int PSC_W = (1 << SEL_W) - 1;

  logic [PSC_W-1:0] psc_q, psc_d, mask;
  logic             step, hit;

  for (genvar i = 0; i < PSC_W; i++) begin : g_mask
    assign mask[i] = (sel_i > SEL_W'(i));
  end

  assign step  = pulse_i & en_i;
  assign hit   = ((psc_q & mask) == mask);
  assign adv_o = step & hit & ~clr_i;

  always_comb begin
    psc_d = psc_q;
    if (clr_i)     psc_d = '0;
    else if (step) psc_d = hit ? '0 : psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  input  logic                clr_i,
  input  logic                ld_lo_i,
  input  logic                ld_hi_i,
  input  logic [BYTE_W-1:0]   lo_d_i,
  input  logic [BYTE_W-1:0]   hi_d_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                ovf_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;

  assign load  = ld_lo_i | ld_hi_i;
  assign ovf_o = adv_i & (&cnt_q) & ~load & ~clr_i;
  assign cnt_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      if (ld_lo_i) cnt_d[BYTE_W-1:0]     = lo_d_i;
      if (ld_hi_i) cnt_d[CNT_W-1:BYTE_W] = hi_d_i;
    end else if (clr_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ptmr16.sv
module ptmr16
  import ptmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ext_clk_i,
  input  logic              evt_clr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_flag_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] hbuf_q, hbuf_d;
  logic              flag_q, flag_d;
  logic [CNT_W-1:0]  cnt;
  logic              ext_rise, src_pulse, adv, ovf;
  logic              wr_ctrl, wr_lo, wr_hi, wr_flag, rd_lo;
  logic              ld_lo, ld_hi;
  logic [BYTE_W-1:0] hi_d;

  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign wr_lo   = wr_en_i && (addr_i == REG_CNTL);
  assign wr_hi   = wr_en_i && (addr_i == REG_CNTH);
  assign wr_flag = wr_en_i && (addr_i == REG_FLAG);
  assign rd_lo   = rd_en_i && (addr_i == REG_CNTL);

  // buffered mode: a low-byte write commits the shadow high byte
  assign ld_lo = wr_lo;
  assign ld_hi = ctrl_q.mode16 ? wr_lo : wr_hi;
  assign hi_d  = ctrl_q.mode16 ? hbuf_q : wdata_i;

  ptmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_i    (ext_clk_i),
    .bypass_i (ctrl_q.nosync),
    .rise_o   (ext_rise)
  );

  assign src_pulse = ctrl_q.ext_sel ? ext_rise : tick_i;

  ptmr_prescale #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (src_pulse),
    .en_i    (ctrl_q.en),
    .clr_i   (ld_lo | ld_hi),
    .sel_i   (ctrl_q.psc_sel),
    .adv_o   (adv)
  );

  ptmr_count #(.BYTE_W(BYTE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv),
    .clr_i   (evt_clr_i),
    .ld_lo_i (ld_lo),
    .ld_hi_i (ld_hi),
    .lo_d_i  (wdata_i),
    .hi_d_i  (hi_d),
    .cnt_o   (cnt),
    .ovf_o   (ovf)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata_i & CTRL_WMASK);
    hbuf_d = hbuf_q;
    if (ctrl_q.mode16) begin
      if (wr_hi)      hbuf_d = wdata_i;
      else if (rd_lo) hbuf_d = cnt[CNT_W-1:BYTE_W];
    end
    flag_d = flag_q;
    if (ovf)          flag_d = 1'b1;
    else if (wr_flag) flag_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hbuf_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      hbuf_q <= hbuf_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = ctrl_q;
      REG_CNTL: rdata_o = cnt[BYTE_W-1:0];
      REG_CNTH: rdata_o = ctrl_q.mode16 ? hbuf_q : cnt[CNT_W-1:BYTE_W];
      default:  rdata_o = {{(BYTE_W-1){1'b0}}, flag_q};
    endcase
  end

  assign irq_flag_o = flag_q;
endmodule

// File: rtl/ptmr16_chk.sv
module ptmr16_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cnt,
  input logic              adv,
  input logic              load,
  input logic              evt_clr,
  input logic              en,
  input logic              flag,
  input logic              mode16,
  input logic              rd_lo,
  input logic [BYTE_W-1:0] hbuf
);
  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load && !evt_clr) |=> $stable(cnt));

  // R8
  event_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !load) |=> (cnt == '0));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !evt_clr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R7
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (&cnt) && !load && !evt_clr) |=> flag);

  // R9
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && mode16) |=> (hbuf == $past(cnt[CNT_W-1:BYTE_W])));
endmodule

bind ptmr16 ptmr16_chk #(.CNT_W(ptmr_pkg::CNT_W), .BYTE_W(ptmr_pkg::BYTE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (cnt),
  .adv     (adv),
  .load    (ld_lo | ld_hi),
  .evt_clr (evt_clr_i),
  .en      (ctrl_q.en),
  .flag    (flag_q),
  .mode16  (ctrl_q.mode16),
  .rd_lo   (rd_lo),
  .hbuf    (hbuf_q)
);

// File: tb/tb_ptmr16.sv
module tb_ptmr16;
  localparam int HALF = 2;  // 4 ns period, 250 MHz

  logic       clk, rst_n, tick_i, ext_clk_i, evt_clr_i;
  logic       wr_en_i, rd_en_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic       irq_flag_o;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 0;

  ptmr16 dut (.*);

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  // direct-mode helpers
  task automatic set_cnt(input logic [15:0] v);
    bus_wr(2'd2, v[15:8]);
    bus_wr(2'd1, v[7:0]);
  endtask

  task automatic get_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_rd(2'd1, lo);
    bus_rd(2'd2, hi);
    v = {hi, lo};
  endtask

  function automatic logic [7:0] cfg(input bit m16, input logic [1:0] ps,
                                     input bit nosync, input bit ext, input bit en);
    return {m16, 1'b0, ps, 1'b0, nosync, ext, en};
  endfunction

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk_i = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk_i = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0]  d;
    logic [15:0] v;
    bus_rd(2'd0, d); chk("R1 ctrl", {8'h0, d}, 16'h0000);
    get_cnt(v);      chk("R1 count", v, 16'h0000);
    chk("R1 flag", {15'h0, irq_flag_o}, 16'h0000);
  endtask

  task automatic t_ctrl_bits;
    logic [7:0] d;
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, d); chk("R12 ctrl readback", {8'h0, d}, 16'h00B7);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 1));
    set_cnt(16'h0100);
    ticks(25);
    get_cnt(v); chk("R2 timer 25 ticks", v, 16'h0119);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      bus_wr(2'd0, cfg(0, 2'(s), 0, 0, 1));
      set_cnt(16'h0000);
      ticks(16);
      get_cnt(v); chk("R3 ratio", v, 16'(16 >> s));
    end
    bus_wr(2'd0, cfg(0, 2'd2, 0, 0, 1));
    set_cnt(16'h0000);
    ticks(3);
    get_cnt(v); chk("R3 div4 after 3", v, 16'h0000);
    ticks(1);
    get_cnt(v); chk("R3 div4 after 4", v, 16'h0001);
  endtask

  task automatic t_disable;
    logic [15:0] v;
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 0));
    set_cnt(16'h0033);
    ticks(10);
    get_cnt(v); chk("R4 disabled hold", v, 16'h0033);
  endtask

  task automatic t_psc_clear;
    logic [15:0] v;
    bus_wr(2'd0, cfg(0, 2'd3, 0, 0, 1));
    set_cnt(16'h0000);
    ticks(7);
    set_cnt(16'h0000);
    ticks(7);
    get_cnt(v); chk("R13 write clears prescaler", v, 16'h0000);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    tick_i = 1'b1;  // must be ignored in counter mode
    bus_wr(2'd0, cfg(0, 2'd1, 0, 1, 1));
    set_cnt(16'h0000);
    ext_pulses(6);
    get_cnt(v); chk("R5 sync ext div2", v, 16'h0003);
    bus_wr(2'd0, cfg(0, 2'd0, 1, 1, 1));
    set_cnt(16'h0000);
    ext_pulses(5);
    get_cnt(v); chk("R5 async ext div1", v, 16'h0005);
    tick_i = 1'b0;
  endtask

  task automatic t_latency(input bit nosync);
    bus_wr(2'd0, cfg(0, 2'd0, nosync, 1, 1));
    set_cnt(16'h0000);
    addr_i = 2'd1;
    @(negedge clk); ext_clk_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(nosync ? "R6 async after k+1" : "R6 sync after k+1",
        {8'h0, rdata_o}, nosync ? 16'h0001 : 16'h0000);
    @(negedge clk);
    chk(nosync ? "R6 async after k+2" : "R6 sync after k+2",
        {8'h0, rdata_o}, 16'h0001);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    logic [7:0]  d;
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 1));
    set_cnt(16'hFFFE);
    ticks(1);
    chk("R7 no flag before wrap", {15'h0, irq_flag_o}, 16'h0000);
    ticks(1);
    get_cnt(v); chk("R7 wrapped count", v, 16'h0000);
    chk("R7 flag set", {15'h0, irq_flag_o}, 16'h0001);
    ticks(3);
    bus_rd(2'd3, d); chk("R7 flag sticky", {8'h0, d}, 16'h0001);
    bus_wr(2'd3, 8'h00);
    chk("R7 flag cleared by write", {15'h0, irq_flag_o}, 16'h0000);
  endtask

  task automatic t_event;
    logic [15:0] v;
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 1));
    set_cnt(16'h0040);
    @(negedge clk); evt_clr_i = 1'b1;
    @(negedge clk); evt_clr_i = 1'b0;
    get_cnt(v); chk("R8 event clear", v, 16'h0000);
    set_cnt(16'h0077);
    @(negedge clk); evt_clr_i = 1'b1; tick_i = 1'b1;
    @(negedge clk); evt_clr_i = 1'b0; tick_i = 1'b0;
    get_cnt(v); chk("R8 clear beats tick", v, 16'h0000);
  endtask

  task automatic t_buffered;
    logic [7:0]  d;
    logic [15:0] v;
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 0));
    set_cnt(16'h12FF);
    bus_wr(2'd0, cfg(1, 2'd0, 0, 0, 1));
    bus_rd(2'd1, d); chk("R9 low read", {8'h0, d}, 16'h00FF);
    ticks(1);
    bus_rd(2'd2, d); chk("R9 shadow high", {8'h0, d}, 16'h0012);
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 0));
    bus_rd(2'd2, d); chk("R11 live high", {8'h0, d}, 16'h0013);
    bus_wr(2'd0, cfg(1, 2'd0, 0, 0, 0));
    bus_wr(2'd2, 8'hAB);
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 0));
    get_cnt(v); chk("R10 high write only buffered", v, 16'h1300);
    bus_wr(2'd0, cfg(1, 2'd0, 0, 0, 0));
    bus_wr(2'd1, 8'hCD);
    bus_wr(2'd0, cfg(0, 2'd0, 0, 0, 0));
    get_cnt(v); chk("R10 atomic commit", v, 16'hABCD);
    bus_wr(2'd2, 8'h5A);
    get_cnt(v); chk("R11 direct high write", v, 16'h5ACD);
    bus_wr(2'd1, 8'h01);
    get_cnt(v); chk("R11 direct low write", v, 16'h5A01);
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; ext_clk_i = 1'b0; evt_clr_i = 1'b0;
    wr_en_i = 1'b0; rd_en_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl_bits;
    t_timer;
    t_prescale;
    t_disable;
    t_psc_clear;
    t_ext;
    t_latency(1'b0);
    t_latency(1'b1);
    t_overflow;
    t_event;
    t_buffered;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule